// File: doc/BRIEF.md
# Dual-Band FIR Filter with Bank Freezing

This block filters one stream of signed 16-bit samples through two fully parallel FIR banks. The banks are built the same way and differ only in their coefficient sets: one is a high-pass bank and one is a low-pass bank. Every accepted sample is multiplied against all taps of both banks in the same cycle. Each bank's full-precision sum is scaled down by an arithmetic right shift. The responses of the selected banks are then added and clipped to a signed 16-bit result.

Two select bits pick which banks reach the output. A bank that is not selected can also be frozen, so that its tap history does not move. There are two ways to freeze it. Register enables freeze it when `reg_mode` is 1. A latch-based clock gate cell freezes it when `test_mode` is 0; `test_mode` at 1 keeps every clock running.

Samples enter on a valid/ready handshake and results leave on another. An input sample is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being read in the same cycle. A result that is held with `out_ready` low stays unchanged until it is read. That back-pressure stops new samples from entering.

Top module: `dual_band_fir`

## Requirements
- R1: A synchronous active-low reset clears both tap histories and the output register. After reset, `out_valid` is 0 and `out_data` is 0. This also holds while a bank's clock would otherwise be gated.
- R2: A sample taken on edge n sets `out_valid` and a new `out_data` on that same edge. That value is readable one cycle after the sample is presented. Each bank computes y = floor((c0·x[n] + c1·x[n-1] + … ) / 2^15) over its own tap history. The output is the sum of the selected bank results, with the bank coefficients in tap order.
- R3: `band_sel[0]` adds the high-pass result and `band_sel[1]` adds the low-pass result. A bank that is not selected adds zero, and `band_sel` = 0 gives an output of 0.
- R4: The sum is saturated to the range −32768 to 32767.
- R5: While `reg_mode` is 1, an unselected bank's tap history does not advance. When that bank is selected again, its result uses the history it held when it was frozen.
- R6: While `test_mode` is 0, the clock of an unselected bank is stopped through a glitch-free latch gate, and its tap history is frozen.
- R7: With `test_mode` = 1 and `reg_mode` = 0, both banks advance on every taken sample, whatever `band_sel` is. The control word {test_mode, reg_mode, band_sel[1], band_sel[0]} gives these settings: 15 means both banks on; 14 means the high-pass bank is off and frozen by its enables; 2 means low-pass only, with the high-pass clock gated.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold and `in_ready` is 0. An offered sample is not taken in that state.
- R9: With `in_valid` at 0, no sample is taken and the histories stay unchanged. A read result then clears `out_valid` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| test_mode | input | 1 | 1: clock gates open; 0: gate unselected bank clocks |
| reg_mode | input | 1 | 1: hold unselected bank registers through enables |
| band_sel | input | 2 | Bit 0 high-pass on, bit 1 low-pass on |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Sample will be taken if valid |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 16 | Signed saturated filter output |

## Verification
The bench builds the block with 4 taps per bank and coefficients of ±12000. That gives each bank a gain near 1.46, so saturation at both rails is reached with full-scale inputs. All 16 control words are swept in turn, and each one is fed a sample run of full-scale and mixed values. Tap histories carry over from one control word to the next, so frozen and thawed histories under enables, clock gating and free running are all compared with a bench convolution model. Stalls, idle cycles and a reset in the middle of a run are exercised after the sweep.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  localparam int HP_BAND   = 0;
  localparam int LP_BAND   = 1;
  localparam int NUM_BANDS = 2;
  localparam int DEF_TAPS  = 8;
  localparam int DEF_W     = 16;

  // default coefficient sets, tap 0 in the low bits
  localparam logic [DEF_TAPS*DEF_W-1:0] DEF_LP_COEFS = {DEF_TAPS{16'h1000}};
  localparam logic [DEF_TAPS*DEF_W-1:0] DEF_HP_COEFS = {(DEF_TAPS/2){16'hF000, 16'h1000}};
endpackage

// File: rtl/dbf_clk_gate.sv
module dbf_clk_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  // enable is captured while clk is low, so gclk cannot glitch
  always_latch begin
    if (!clk) en_lat = en;
  end

  assign gclk = clk & en_lat;
endmodule

// File: rtl/dbf_fir_bank.sv
module dbf_fir_bank #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 8,
  parameter int SHIFT  = 15,
  parameter logic [TAPS*DATA_W-1:0] COEFS = '0,
  localparam int ACC_W = 2*DATA_W + $clog2(TAPS),
  localparam int OUT_W = ACC_W - SHIFT
) (
  input  logic                     bclk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [OUT_W-1:0]  y,
  output logic signed [DATA_W-1:0] newest
);
  localparam int LINE = TAPS - 1;

  logic signed [DATA_W-1:0] line_q [LINE];

  for (genvar s = 0; s < LINE; s++) begin : g_stage
    always_ff @(posedge bclk) begin
      if (!rst_n)   line_q[s] <= '0;
      else if (adv) line_q[s] <= (s == 0) ? din : line_q[(s == 0) ? 0 : s-1];
    end
  end

  logic signed [ACC_W-1:0]    acc;
  logic signed [2*DATA_W-1:0] prod;
  logic signed [DATA_W-1:0]   cf;
  logic signed [DATA_W-1:0]   tap_x;

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) begin
      cf    = $signed(COEFS[k*DATA_W +: DATA_W]);
      tap_x = (k == 0) ? din : line_q[(k == 0) ? 0 : k-1];
      prod  = cf * tap_x;
      acc   = acc + ACC_W'(prod);
    end
  end

  assign y      = OUT_W'(acc >>> SHIFT);
  assign newest = line_q[0];
endmodule

// File: rtl/dual_band_fir.sv
module dual_band_fir
  import dbf_pkg::*;
#(
  parameter int DATA_W     = DEF_W,
  parameter int TAPS       = DEF_TAPS,
  parameter int COEF_SHIFT = 15,
  parameter logic [TAPS*DATA_W-1:0] HP_COEFS = DEF_HP_COEFS,
  parameter logic [TAPS*DATA_W-1:0] LP_COEFS = DEF_LP_COEFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              reg_mode,
  input  logic [1:0]        band_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int ACC_W  = 2*DATA_W + $clog2(TAPS);
  localparam int BANK_W = ACC_W - COEF_SHIFT;
  localparam int SUM_W  = BANK_W + 1;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((64'sd1 <<< (DATA_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - 1;

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  logic signed [BANK_W-1:0] bank_y   [NUM_BANDS];
  logic signed [DATA_W-1:0] bank_new [NUM_BANDS];

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    localparam logic [TAPS*DATA_W-1:0] CF = (b == HP_BAND) ? HP_COEFS : LP_COEFS;
    logic gate_en, reg_run, gclk;

    assign gate_en = test_mode || band_sel[b] || !rst_n;
    assign reg_run = !reg_mode || band_sel[b];

    dbf_clk_gate u_gate (
      .clk  (clk),
      .en   (gate_en),
      .gclk (gclk)
    );

    dbf_fir_bank #(
      .DATA_W (DATA_W),
      .TAPS   (TAPS),
      .SHIFT  (COEF_SHIFT),
      .COEFS  (CF)
    ) u_bank (
      .bclk   (gclk),
      .rst_n  (rst_n),
      .adv    (take && reg_run),
      .din    ($signed(in_data)),
      .y      (bank_y[b]),
      .newest (bank_new[b])
    );
  end

  logic signed [DATA_W-1:0] hp_newest, lp_newest;
  assign hp_newest = bank_new[HP_BAND];
  assign lp_newest = bank_new[LP_BAND];

  logic signed [SUM_W-1:0]  sum;
  logic signed [DATA_W-1:0] sat;

  always_comb begin
    sum = '0;
    for (int b = 0; b < NUM_BANDS; b++)
      if (band_sel[b]) sum = sum + SUM_W'(bank_y[b]);
    if (sum > SAT_HI)      sat = SAT_HI[DATA_W-1:0];
    else if (sum < SAT_LO) sat = SAT_LO[DATA_W-1:0];
    else                   sat = sum[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= sat;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_band_fir_chk.sv
module dual_band_fir_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              test_mode,
  input logic              reg_mode,
  input logic [1:0]        band_sel,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [DATA_W-1:0] hp_newest,
  input logic [DATA_W-1:0] lp_newest
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_data == '0));

  // R2
  take_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R3
  empty_select_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && band_sel == 2'b00) |=> out_data == '0);

  // R5
  reg_freeze_hp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode && !band_sel[0]) |=> $stable(hp_newest));

  // R5
  reg_freeze_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode && !band_sel[1]) |=> $stable(lp_newest));

  // R6
  gate_freeze_hp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !band_sel[0]) |=> $stable(hp_newest));

  // R6
  gate_freeze_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !band_sel[1]) |=> $stable(lp_newest));

  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  idle_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(hp_newest) && $stable(lp_newest)));

  // R9
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);
endmodule

bind dual_band_fir dual_band_fir_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .test_mode (test_mode),
  .reg_mode  (reg_mode),
  .band_sel  (band_sel),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .hp_newest (hp_newest),
  .lp_newest (lp_newest)
);

// File: tb/dual_band_fir_bench.sv
module dual_band_fir_bench;
  localparam int W = 16;
  localparam int T = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b0, reg_mode = 1'b0;
  logic [1:0] band_sel = 2'b00;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_data;

  always #4 clk = ~clk;

  dual_band_fir #(
    .DATA_W(W), .TAPS(T), .COEF_SHIFT(15),
    .HP_COEFS({16'hD120, 16'h2EE0, 16'hD120, 16'h2EE0}),
    .LP_COEFS({16'h2EE0, 16'h2EE0, 16'h2EE0, 16'h2EE0})
  ) u_dual_band_fir (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .reg_mode(reg_mode),
    .band_sel(band_sel), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  int hp_c[T] = '{12000, -12000, 12000, -12000};
  int lp_c[T] = '{12000, 12000, 12000, 12000};
  int hl[T-1], ll[T-1];
  int total = 0, bad = 0;
  bit exp_valid = 0;
  int exp_data = 0;
  bit finished = 0;

  function automatic int bank(input int c[T], input int l[T-1], input int x);
    longint acc = longint'(c[0]) * x;
    for (int k = 1; k < T; k++) acc += longint'(c[k]) * l[k-1];
    return int'(acc >>> 15);
  endfunction

  task automatic check(input string lbl, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", lbl, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < T-1; k++) begin hl[k] = 0; ll[k] = 0; end
    exp_valid = 0; exp_data = 0;
  endtask

  task automatic set_mode(input int m);
    test_mode = m[3]; reg_mode = m[2]; band_sel = m[1:0];
  endtask

  // called at a negedge; checks at the following negedge
  task automatic step(input bit v, input int d, input bit ordy);
    bit rdy, tk, satd;
    int x, sum;
    string lbl;
    in_valid = v; in_data = d[W-1:0]; out_ready = ordy;
    x = int'($signed(d[W-1:0]));
    rdy = !exp_valid || ordy;
    tk = v && rdy;
    satd = 0;
    #1;
    check("R8", in_ready === rdy, int'(in_ready), int'(rdy));
    if (tk) begin
      sum = 0;
      if (band_sel[0]) sum += bank(hp_c, hl, x);
      if (band_sel[1]) sum += bank(lp_c, ll, x);
      if (sum > 32767)  begin sum = 32767;  satd = 1; end
      if (sum < -32768) begin sum = -32768; satd = 1; end
      if (band_sel[0] || (test_mode && !reg_mode)) begin
        for (int k = T-2; k > 0; k--) hl[k] = hl[k-1];
        hl[0] = x;
      end
      if (band_sel[1] || (test_mode && !reg_mode)) begin
        for (int k = T-2; k > 0; k--) ll[k] = ll[k-1];
        ll[0] = x;
      end
      exp_valid = 1; exp_data = sum;
    end else if (ordy) exp_valid = 0;

    if (!ordy)                                  lbl = "R8";
    else if (!v)                                lbl = "R9";
    else if (satd)                              lbl = "R4";
    else if (!test_mode && band_sel != 2'b11)   lbl = "R6";
    else if (reg_mode && band_sel != 2'b11)     lbl = "R5";
    else if (test_mode && !reg_mode)            lbl = "R7";
    else if (band_sel != 2'b11)                 lbl = "R3";
    else                                        lbl = "R2";

    @(negedge clk);
    check(lbl, out_valid === exp_valid, int'(out_valid), int'(exp_valid));
    if (exp_valid)
      check(lbl, $signed(out_data) == exp_data, int'($signed(out_data)), exp_data);
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0;
    repeat (3) @(negedge clk);
    clear_model();
    check("R1", out_valid === 1'b0, int'(out_valid), 0);
    check("R1", out_data === '0, int'(out_data), 0);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    set_mode(2);          // R1 under gating
    do_reset();
    // sweep all control words; histories carry over between words
    for (int m = 0; m < 16; m++) begin
      set_mode(m);
      for (int i = 0; i < 20; i++) begin
        int d;
        case (i % 5)
          0: d = 32'h7FFF;
          1: d = 32'h8000;
          default: d = ((i * 40503 + m * 977) ^ (i << 9)) & 32'hFFFF;
        endcase
        step(1, d, 1);
      end
    end
    // R8 stall: result held, offered samples refused
    set_mode(15);
    step(1, 16'h1234, 1);
    step(1, 16'h2222, 0);
    for (int i = 0; i < 3; i++) step(1, 16'h7000 + i, 0);
    step(1, 16'h0F0F, 1);
    // R9 idle cycles
    step(0, 16'h7FFF, 1);
    step(0, 16'h7FFF, 1);
    step(1, 16'h0100, 1);
    // R1 reset in mid run, then fresh history
    set_mode(14);
    do_reset();
    set_mode(15);
    for (int i = 0; i < 6; i++) step(1, (i * 5003) & 32'hFFFF, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule